// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block generates the word addresses for one DMA channel that moves a rectangular region of memory. Software supplies a byte start address, a line length in words, a line stride in words and a line count minus one. Asserting `start` while the channel is idle loads these settings and begins the transfer. The block then offers one address per beat on a valid/ready handshake, together with a direction flag and a burst-mode flag. When the last beat of the last line is taken, it pulses `done` and returns to idle.

A line length of zero selects ring mode. The address walks through a region of stride × (count + 1) words, wraps back to the start, and never finishes by itself. An interrupt pulse marks each point where a half of the ring has been consumed. A synchronous `abort` stops either mode at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `req_valid`, `done` and `half_irq` are low.
- R2: A `start` pulse while idle loads `start_byte` bits [AW+1:2] as the first word address. It also latches the length, stride, count, direction and burst inputs. `req_valid` rises on the following cycle.
- R3: While `req_valid` is high and `req_ready` is low, `req_addr` holds its value. The address advances only on an accepted beat.
- R4: With a nonzero line length L, the beats carry the addresses start + y·stride + x, for x in 0..L-1 and y in 0..count, in that order.
- R5: `done` is high for exactly one cycle, in the cycle after the final beat is accepted. `req_valid` is low in that same cycle.
- R6: A line length of zero selects ring mode. The address runs from start through start + N-1, where N = stride·(count+1), then wraps to start. `done` never rises in this mode. N must be even and at least 2.
- R7: In ring mode, `half_irq` pulses for one cycle after each accepted beat at offset N/2-1 and at offset N-1, on every pass.
- R8: `req_dir` reflects the latched direction bit (1 = memory to device, 0 = device to memory). `req_burst` reflects the latched burst bit (1 = four-word bursts, 0 = single words). Changes on `dir` or `burst` during a transfer have no effect.
- R9: A `start` pulse while a transfer is running is ignored, and the address sequence continues unchanged.
- R10: `abort` makes the block idle on the next cycle with `done` and `half_irq` low. It takes priority over a simultaneous `start` and over a simultaneous final or half-point acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (ignored when busy) |
| start_byte | input | AW+2 | Start byte address; the low two bits are dropped |
| line_len | input | LW | Words per line; 0 selects ring mode |
| line_stride | input | LW | Words between successive line starts |
| line_cnt | input | CW | Number of lines minus one |
| dir | input | 1 | 1 = memory to device, 0 = device to memory |
| burst | input | 1 | 1 = four-word bursts, 0 = single words |
| abort | input | 1 | Synchronous stop |
| req_ready | input | 1 | Consumer accepts the current beat |
| req_valid | output | 1 | An address beat is offered |
| req_addr | output | AW | Word address of the current beat |
| req_dir | output | 1 | Latched direction |
| req_burst | output | 1 | Latched burst mode |
| done | output | 1 | One-cycle end-of-transfer pulse |
| half_irq | output | 1 | One-cycle ring half-point pulse |

## Verification
The competing events are `abort` landing in the same cycle as an acceptance that would raise a pulse. The bench drives `abort` together with `req_ready` on the final beat of a finite transfer, and again on a half-point beat of a ring transfer. It then checks on the next cycle that neither `done` nor `half_irq` appears and that `req_valid` has dropped. A second collision, `abort` together with `start` while idle, is judged by `req_valid` staying low.

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 30,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW+1:0] start_byte,
  input  logic [LW-1:0] line_len,
  input  logic [LW-1:0] line_stride,
  input  logic [CW-1:0] line_cnt,
  input  logic          dir,
  input  logic          burst,
  input  logic          abort,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic          req_dir,
  output logic          req_burst,
  output logic          done,
  output logic          half_irq
);
  localparam int RW = LW + CW + 1;

  logic          busy, ring;
  logic [AW-1:0] addr, base;
  logic [LW-1:0] len_q, stride_q, xcnt;
  logic [CW-1:0] ylast, ycnt;
  logic [RW-1:0] off, ring_last, half_last, region;
  logic          dir_q, burst_q, done_q, irq_q;

  assign region    = RW'(line_stride) * (RW'(line_cnt) + RW'(1));
  assign req_valid = busy;
  assign req_addr  = addr;
  assign req_dir   = dir_q;
  assign req_burst = burst_q;
  assign done      = done_q;
  assign half_irq  = irq_q;

  wire x_end = (xcnt == len_q - LW'(1));
  wire y_end = (ycnt == ylast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ring <= 1'b0; addr <= '0; base <= '0;
      len_q <= '0; stride_q <= '0; xcnt <= '0; ylast <= '0; ycnt <= '0;
      off <= '0; ring_last <= '0; half_last <= '0;
      dir_q <= 1'b0; burst_q <= 1'b0; done_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          ring      <= (line_len == '0);
          addr      <= start_byte[AW+1:2];
          base      <= start_byte[AW+1:2];
          len_q     <= line_len;
          stride_q  <= line_stride;
          ylast     <= line_cnt;
          xcnt      <= '0;
          ycnt      <= '0;
          off       <= '0;
          ring_last <= region - RW'(1);
          half_last <= (region >> 1) - RW'(1);
          dir_q     <= dir;
          burst_q   <= burst;
        end
      end else if (req_ready) begin
        if (ring) begin
          if (off == ring_last) begin
            off   <= '0;
            addr  <= base;
            irq_q <= 1'b1;
          end else begin
            off  <= off + RW'(1);
            addr <= addr + AW'(1);
            if (off == half_last) irq_q <= 1'b1;
          end
        end else if (x_end) begin
          if (y_end) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ycnt <= ycnt + CW'(1);
            xcnt <= '0;
            base <= base + AW'(stride_q);
            addr <= base + AW'(stride_q);
          end
        end else begin
          xcnt <= xcnt + LW'(1);
          addr <= addr + AW'(1);
        end
      end
    end
  end
endmodule

module dma2d_addr_gen_chk #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW+1:0] start_byte,
  input logic          abort,
  input logic          req_ready,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          done,
  input logic          half_irq
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req_valid && !abort) |=> (req_valid && req_addr == $past(start_byte[AW+1:2])));

  assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !abort) |=> (req_valid && $stable(req_addr)));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_irq_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_irq |-> (req_valid && !done));

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!req_valid && !done && !half_irq));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_byte(start_byte),
  .abort(abort), .req_ready(req_ready), .req_valid(req_valid),
  .req_addr(req_addr), .done(done), .half_irq(half_irq)
);

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
  localparam int AW = 30, LW = 16, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0, burst = 1'b0, abort = 1'b0, req_ready = 1'b0;
  logic [AW+1:0] start_byte = '0;
  logic [LW-1:0] line_len = '0, line_stride = '0;
  logic [CW-1:0] line_cnt = '0;
  logic req_valid, req_dir, req_burst, done, half_irq;
  logic [AW-1:0] req_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .LW(LW), .CW(CW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_nl(input int sb, input int len, input int str, input int lines,
                        input bit d, input bit b, input int seed, input bit poke);
    int total, k, cyc;
    logic [AW-1:0] held;
    bit hold;
    logic [AW-1:0] sw;
    sw = AW'(sb >> 2);
    @(negedge clk);
    start_byte = (AW+2)'(sb); line_len = LW'(len); line_stride = LW'(str);
    line_cnt = CW'(lines); dir = d; burst = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dir = ~d; burst = ~b;
    total = len * (lines + 1); k = 0; cyc = 0; hold = 0; held = '0;
    while (k < total) begin
      req_ready = ((cyc * 5 + seed) % 3) != 0;
      if (poke && cyc == 2) begin start = 1'b1; start_byte = 32'h0000_F000; end
      else start = 1'b0;
      cyc++;
      #1;
      chk(done == 1'b0, "R5 early done", done, 0);
      chk(req_valid == 1'b1, "R4 valid", req_valid, 1);
      if (hold) chk(req_addr == held, "R3 hold", req_addr, held);
      if (req_valid && req_ready) begin
        chk(req_addr == sw + AW'((k / len) * str + (k % len)),
            poke ? "R9 addr" : "R4 addr", req_addr, sw + AW'((k / len) * str + (k % len)));
        if (k == 0) begin
          chk(k == 0 && cyc == 1 ? req_addr == sw : 1'b1, "R2 first", req_addr, sw);
          chk(req_dir == d && req_burst == b, "R8 flags", {req_dir, req_burst}, {d, b});
        end else if (k == total - 1) begin
          chk(req_dir == d && req_burst == b, "R8 flags held", {req_dir, req_burst}, {d, b});
        end
        k++; hold = 0;
      end else begin
        hold = 1; held = req_addr;
      end
      @(negedge clk);
    end
    req_ready = 1'b0; start = 1'b0;
    #1;
    chk(done == 1'b1, "R5 done", done, 1);
    chk(req_valid == 1'b0, "R5 idle", req_valid, 0);
    @(negedge clk); #1;
    chk(done == 1'b0, "R5 one cycle", done, 0);
  endtask

  task automatic run_ring();
    int k, cyc;
    bit exp_irq;
    k = 0; cyc = 0; exp_irq = 0;
    @(negedge clk);
    start_byte = 32'h0000_1003; line_len = '0; line_stride = 16'd2; line_cnt = 16'd3;
    dir = 1'b1; burst = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < 23) begin
      req_ready = ((cyc * 7 + 1) % 4) != 0;
      cyc++;
      #1;
      chk(half_irq == exp_irq, "R7 irq", half_irq, exp_irq);
      chk(done == 1'b0, "R6 no done", done, 0);
      exp_irq = 0;
      if (req_valid && req_ready) begin
        chk(req_addr == AW'(30'h400 + (k % 8)), "R6 ring addr", req_addr, 30'h400 + (k % 8));
        exp_irq = (k % 4) == 3;
        k++;
      end
      @(negedge clk);
    end
    #1;
    chk(half_irq == exp_irq, "R7 irq", half_irq, exp_irq);
    chk(req_addr == AW'(30'h407), "R6 ring addr", req_addr, 30'h407);
    req_ready = 1'b1; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0; req_ready = 1'b0;
    #1;
    chk(half_irq == 1'b0, "R10 irq suppressed", half_irq, 0);
    chk(req_valid == 1'b0, "R10 idle", req_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_valid == 0 && done == 0 && half_irq == 0, "R1 reset", {req_valid, done, half_irq}, 0);
    rst_n = 1'b1;

    for (int len = 1; len <= 3; len++)
      for (int s = 0; s <= 1; s++)
        for (int lines = 0; lines <= 2; lines++)
          run_nl(32'h100 + len * 64 + s * 16 + lines * 4 + (lines & 3), len, len + s,
                 lines, bit'(lines & 1), bit'(s), len + lines, 1'b0);

    run_nl(32'h2000, 3, 5, 2, 1'b0, 1'b1, 2, 1'b1);
    run_ring();

    // R10: abort on the final beat suppresses done
    @(negedge clk);
    start_byte = 32'h400; line_len = 16'd2; line_stride = 16'd2; line_cnt = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; req_ready = 1'b1;
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0; req_ready = 1'b0;
    #1;
    chk(done == 1'b0, "R10 done suppressed", done, 0);
    chk(req_valid == 1'b0, "R10 idle", req_valid, 0);

    // R10: abort beats start
    @(negedge clk);
    start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    #1;
    chk(req_valid == 1'b0, "R10 abort over start", req_valid, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule